// File: doc/BRIEF.md
# Watchdog Timer with Gated Reset Request

This block is a down-counting watchdog for a system-on-chip. Software programs a duration into a count register, chooses the count clock and then sets the enable bit. The count clock is either the system clock divided by a power of two or pulses on a fixed reference tick input. Software must rewrite the count register often enough to keep the counter away from zero. When the count falls from 1 to 0, a sticky expired flag is set. An interrupt level is raised while the timer stays enabled.

A reset request level can follow the expiry, but only through two gates. One is a dedicated reset-output enable register. The other is an active-high reset-mask register that blocks the request whenever it is set. Accesses are single-cycle: a write is captured on the clock edge while `bus_wr` is high, and `bus_rdata` shows the addressed register combinationally. Unmapped addresses read as zero.

Top module: `wdg_rstgate`

## Requirements
- R1: After reset, every register reads zero and both `irq` and `rst_req` are low.
- R2: The control register at 0x00 holds the enable (bit 8), the reference-clock select (bit 10) and a 5-bit ratio field (bits 20:16). It reads back only those bits. While bit 8 is clear, the counter does not change.
- R3: The 32-bit count register at 0x34 is loaded by a write and reads back the remaining count. The value 0xFFFFFFFF can be loaded and read back.
- R4: With bit 10 clear and ratio N, the enabled counter decrements once every 2^N clock cycles. The first decrement comes 2^N cycles after the enable write or a count write.
- R5: With bit 10 set, the enabled counter decrements once in each cycle in which `ref_tick` is high. The ratio field has no effect in this mode.
- R6: A decrement from 1 to 0 sets the expired flag (status register 0x04, bit 31), and the counter then holds at 0. A counter loaded with 0 never sets the flag.
- R7: Writing 0 to status bit 31 clears the expired flag. Writing 1 to it leaves the flag unchanged.
- R8: Writing the count register while the timer runs restarts the countdown from the written value.
- R9: `irq` is high exactly when the expired flag and the enable bit are both set.
- R10: `rst_req` is high only when the expired flag, the enable bit and the reset-output enable (register 0x40, bit 8) are set and the reset mask (register 0x44, bit 10) is clear. Both registers read back only their one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| ref_tick | input | 1 | Fixed reference count pulse, one cycle per tick |
| irq | output | 1 | Expiry interrupt level |
| rst_req | output | 1 | Gated system reset request level |

## Verification
The countdown runs from a table that pairs ratios 0, 1, 2, 3 and 5 with different load values. Measuring the cycles until the interrupt rises shows whether the ratio, the load and the prescaler restart each set the period, since every row gives a different product. The reference-tick mode is driven with sparse, irregular pulses and a ratio of 5. This shows that only the pulses are counted and that the divider is bypassed. Directed sequences cover reloading in mid-count with an odd prescaler phase, a load of zero, the maximum load, clearing the sticky flag, and each combination of enable, reset-output enable and mask on the reset request.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the watchdog with gated reset request.
// Assumes byte offsets that fit in the top-level address width.
package wdg_pkg;
    localparam int REG_W          = 32;
    localparam int RATIO_W        = 5;

    localparam int OFS_CTRL       = 'h00;
    localparam int OFS_STAT       = 'h04;
    localparam int OFS_COUNT      = 'h34;
    localparam int OFS_RSTEN      = 'h40;
    localparam int OFS_RMASK      = 'h44;

    localparam int CTRL_EN_BIT    = 8;
    localparam int CTRL_REF_BIT   = 10;
    localparam int CTRL_RATIO_LSB = 16;
    localparam int STAT_EXP_BIT   = 31;
    localparam int RSTEN_BIT      = 8;
    localparam int RMASK_BIT      = 10;

    typedef struct packed {
        logic               en;
        logic               refsel;
        logic [RATIO_W-1:0] ratio;
    } ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
// Register file and address decode for the watchdog.
// Captures single-cycle writes, makes the count-load and flag-clear
// strobes, and drives combinational read data. Assumes one access per cycle.
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              expired,
    output ctrl_t             ctrl,
    output logic              rst_en,
    output logic              rst_mask,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  ld_val,
    output logic              clr_req,
    output logic [REG_W-1:0]  rdata
);
    logic sel_ctrl, sel_stat, sel_cnt, sel_rsten, sel_rmask;

    // Decode the byte offset into one select per register.
    always_comb begin
        sel_ctrl  = (addr == ADDR_W'(OFS_CTRL));
        sel_stat  = (addr == ADDR_W'(OFS_STAT));
        sel_cnt   = (addr == ADDR_W'(OFS_COUNT));
        sel_rsten = (addr == ADDR_W'(OFS_RSTEN));
        sel_rmask = (addr == ADDR_W'(OFS_RMASK));
    end

    // Store the control and reset-gating registers on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            rst_en   <= 1'b0;
            rst_mask <= 1'b0;
        end else if (wr) begin
            if (sel_ctrl) begin
                ctrl.en     <= wdata[CTRL_EN_BIT];
                ctrl.refsel <= wdata[CTRL_REF_BIT];
                ctrl.ratio  <= wdata[CTRL_RATIO_LSB +: RATIO_W];
            end
            if (sel_rsten) rst_en   <= wdata[RSTEN_BIT];
            if (sel_rmask) rst_mask <= wdata[RMASK_BIT];
        end
    end

    // Make the strobes consumed by the counter.
    always_comb begin
        cnt_wr  = wr && sel_cnt;
        ld_val  = wdata[CNT_W-1:0];
        clr_req = wr && sel_stat && !wdata[STAT_EXP_BIT];
    end

    // Return the addressed register, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[CTRL_EN_BIT]                   = ctrl.en;
            rdata[CTRL_REF_BIT]                  = ctrl.refsel;
            rdata[CTRL_RATIO_LSB +: RATIO_W]     = ctrl.ratio;
        end
        if (sel_stat)  rdata[STAT_EXP_BIT] = expired;
        if (sel_cnt)   rdata = REG_W'(cnt);
        if (sel_rsten) rdata[RSTEN_BIT] = rst_en;
        if (sel_rmask) rdata[RMASK_BIT] = rst_mask;
    end
endmodule

// File: rtl/wdg_prescale.sv
`timescale 1ns/1ps
// Count-tick generator. In divided mode it makes one tick every 2^ratio
// cycles from a counter that restarts on disable or on a count load. In
// reference mode it passes ref_tick through. Assumes ref_tick is
// synchronous to clk and one cycle wide per event.
module wdg_prescale #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               refsel,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               restart,
    input  logic               ref_tick,
    output logic               tick
);
    localparam int PRE_W = 2 ** RATIO_W;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lane;
    logic             div_tick;

    // Free-running divider phase, reset whenever counting is off or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) pre <= '0;
        else                          pre <= pre + PRE_W'(1);
    end

    // Each divider bit below the ratio must be one, the bits above are ignored.
    for (genvar i = 0; i < PRE_W; i++) begin : g_lane
        assign lane[i] = pre[i] | (int'(ratio) <= i);
    end

    // Select the tick source and gate it with the enable.
    always_comb begin
        div_tick = &lane;
        tick     = en && (refsel ? ref_tick : div_tick);
    end
endmodule

// File: rtl/wdg_downcnt.sv
`timescale 1ns/1ps
// Down counter with sticky expiry flag. A load has priority over a tick.
// The flag is set on a 1-to-0 step and cleared by request; a set in the
// same cycle wins over a clear. Assumes tick already includes the enable.
module wdg_downcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             tick,
    input  logic             clr_req,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);
    logic at_one;
    logic step;

    // Qualify a decrement and spot the final step.
    always_comb begin
        step   = tick && !load && (cnt != '0);
        at_one = (cnt == CNT_W'(1));
    end

    // Load or decrement the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= ld_val;
        else if (step) cnt <= cnt - CNT_W'(1);
    end

    // Set the expired flag on the last step, clear it on request.
    always_ff @(posedge clk) begin
        if (!rst_n)              expired <= 1'b0;
        else if (step && at_one) expired <= 1'b1;
        else if (clr_req)        expired <= 1'b0;
    end
endmodule

// File: rtl/wdg_gate.sv
`timescale 1ns/1ps
// Output gating: the interrupt follows flag and enable, the reset
// request additionally needs the reset enable and a clear mask.
module wdg_gate (
    input  logic expired,
    input  logic en,
    input  logic rst_en,
    input  logic rst_mask,
    output logic irq,
    output logic rst_req
);
    // Combine the stored state into the two output levels.
    always_comb begin
        irq     = expired && en;
        rst_req = irq && rst_en && !rst_mask;
    end
endmodule

// File: rtl/wdg_rstgate.sv
`timescale 1ns/1ps
// Top of the watchdog with gated reset request. Connects register
// decode, tick generator, down counter and output gating. Assumes a
// single-cycle register access with combinational read data.
module wdg_rstgate
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ref_tick,
    output logic              irq,
    output logic              rst_req
);
    ctrl_t            ctrl_q;
    logic             ctrl_en, ctrl_ref;
    logic             rst_en_q, rst_mask_q;
    logic             cnt_wr, clr_req, tick, expired_q;
    logic [CNT_W-1:0] ld_val, cnt_q;

    // Flatten control fields for the submodules and the checker.
    always_comb begin
        ctrl_en  = ctrl_q.en;
        ctrl_ref = ctrl_q.refsel;
    end

    wdg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cnt(cnt_q), .expired(expired_q),
        .ctrl(ctrl_q), .rst_en(rst_en_q), .rst_mask(rst_mask_q),
        .cnt_wr(cnt_wr), .ld_val(ld_val), .clr_req(clr_req),
        .rdata(bus_rdata)
    );

    wdg_prescale #(.RATIO_W(RATIO_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .refsel(ctrl_ref),
        .ratio(ctrl_q.ratio), .restart(cnt_wr), .ref_tick(ref_tick),
        .tick(tick)
    );

    wdg_downcnt #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(cnt_wr), .ld_val(ld_val),
        .tick(tick), .clr_req(clr_req), .cnt(cnt_q), .expired(expired_q)
    );

    wdg_gate gate_i (
        .expired(expired_q), .en(ctrl_en), .rst_en(rst_en_q),
        .rst_mask(rst_mask_q), .irq(irq), .rst_req(rst_req)
    );
endmodule

// File: rtl/wdg_rstgate_chk.sv
`timescale 1ns/1ps
// Property checker for the watchdog, bound into the top module.
module wdg_rstgate_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             refsel,
    input logic             ref_tick,
    input logic             tick,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] ld_val,
    input logic             clr_req,
    input logic [CNT_W-1:0] cnt,
    input logic             expired,
    input logic             rst_mask,
    input logic             rst_req
);
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt)); // R2
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(ld_val))); // R3
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R4
    AST_REF_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && refsel && !ref_tick && !cnt_wr) |=> $stable(cnt)); // R5
    AST_EXPIRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt == CNT_W'(1)) |=> (expired && cnt == '0)); // R6
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !cnt_wr) |=> (cnt == '0)); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr_req) |=> expired); // R7
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_mask |-> !rst_req); // R10
endmodule

bind wdg_rstgate wdg_rstgate_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .refsel(ctrl_ref),
    .ref_tick(ref_tick), .tick(tick), .cnt_wr(cnt_wr), .ld_val(ld_val),
    .clr_req(clr_req), .cnt(cnt_q), .expired(expired_q),
    .rst_mask(rst_mask_q), .rst_req(rst_req)
);

// File: tb/wdg_rstgate_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a table of ratio/load/expected-period rows,
// then directed tests of reset, modes and gating.
module wdg_rstgate_tb_top;
    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_CNT = 8'h34,
                           A_RSTEN = 8'h40, A_RMASK = 8'h44;
    localparam logic [31:0] EN = 32'h100, REFM = 32'h400;
    // rows: [39:32] ratio, [31:16] load, [15:0] expected cycles to expiry
    localparam logic [39:0] VEC [5] = '{
        {8'd0, 16'd5, 16'd5},  {8'd1, 16'd3, 16'd6},  {8'd3, 16'd4, 16'd32},
        {8'd5, 16'd2, 16'd64}, {8'd2, 16'd1, 16'd4}};

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, ref_tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, rd;
    logic        irq, rst_req, done = 1'b0;
    logic [39:0] v;
    int          n_chk = 0, n_fail = 0, n;

    always #2 clk = ~clk;

    wdg_rstgate dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_tick(ref_tick), .irq(irq), .rst_req(rst_req));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #0.5; d = bus_rdata;
    endtask

    task automatic idle(input int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    task automatic run_to_irq(output int cyc);
        cyc = 0;
        while (cyc < 5000) begin
            @(negedge clk); cyc++;
            if (irq) break;
        end
    endtask

    task automatic pulse_ref();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3); rst_n = 1'b1; @(negedge clk);
        // R1 reset state
        rdreg(A_CTRL, rd);  chk("R1 ctrl", rd, 0);
        rdreg(A_STAT, rd);  chk("R1 status", rd, 0);
        rdreg(A_CNT, rd);   chk("R1 count", rd, 0);
        rdreg(A_RSTEN, rd); chk("R1 rsten", rd, 0);
        rdreg(A_RMASK, rd); chk("R1 rmask", rd, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 rst_req", {31'd0, rst_req}, 0);

        // R2 field readback and hold while disabled
        wr(A_CTRL, 32'hFFFF_FFFF); rdreg(A_CTRL, rd); chk("R2 ctrl fields", rd, 32'h001F_0500);
        wr(A_CTRL, 0); wr(A_CNT, 100); idle(10);
        rdreg(A_CNT, rd); chk("R2 hold disabled", rd, 100);

        // R3 maximum load and readback of remaining count
        wr(A_CNT, 32'hFFFF_FFFF); rdreg(A_CNT, rd); chk("R3 max load", rd, 32'hFFFF_FFFF);
        wr(A_CTRL, EN); idle(4);
        rdreg(A_CNT, rd); chk("R3 remaining", rd, 32'hFFFF_FFFB);
        wr(A_CTRL, 0);

        // R4 table of divided-mode periods
        for (int i = 0; i < 5; i++) begin
            v = VEC[i];
            wr(A_CTRL, 0); wr(A_STAT, 0);
            wr(A_CNT, {16'd0, v[31:16]});
            wr(A_CTRL, EN | {11'd0, v[36:32], 16'd0});
            run_to_irq(n);
            chk("R4 period", n, {16'd0, v[15:0]});
            rdreg(A_STAT, rd); chk("R6 flag set", rd, 32'h8000_0000);
            idle(3); rdreg(A_CNT, rd); chk("R6 holds zero", rd, 0);
        end

        // R7 sticky flag: write 1 keeps, write 0 clears
        wr(A_STAT, 32'h8000_0000); rdreg(A_STAT, rd); chk("R7 write1 keeps", rd, 32'h8000_0000);
        wr(A_STAT, 0); rdreg(A_STAT, rd); chk("R7 write0 clears", rd, 0);

        // R6 load of zero never expires
        wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_CTRL, EN); idle(10);
        rdreg(A_STAT, rd); chk("R6 zero load no flag", rd, 0);
        chk("R6 zero load no irq", {31'd0, irq}, 0);

        // R5 reference mode, ratio 5 set but ignored
        wr(A_CTRL, 0); wr(A_CNT, 3); wr(A_CTRL, EN | REFM | 32'h0005_0000);
        idle(4); pulse_ref(); idle(5); pulse_ref();
        rdreg(A_CNT, rd); chk("R5 two ref ticks", rd, 1);
        idle(40); rdreg(A_CNT, rd); chk("R5 no ref no count", rd, 1);
        chk("R5 no irq yet", {31'd0, irq}, 0);
        pulse_ref(); chk("R5 expires on third tick", {31'd0, irq}, 1);
        wr(A_CTRL, 0); wr(A_STAT, 0);

        // R8 reload in mid-count with odd prescaler phase
        wr(A_CNT, 5); wr(A_CTRL, EN | 32'h0001_0000); idle(5);
        chk("R8 no early irq", {31'd0, irq}, 0);
        wr(A_CNT, 5); run_to_irq(n); chk("R8 restart period", n, 10);

        // R9 interrupt follows flag and enable
        wr(A_CTRL, 0); chk("R9 irq off when disabled", {31'd0, irq}, 0);
        rdreg(A_STAT, rd); chk("R9 flag kept", rd, 32'h8000_0000);
        wr(A_CTRL, EN); chk("R9 irq back", {31'd0, irq}, 1);

        // R10 reset gating
        chk("R10 no rsten", {31'd0, rst_req}, 0);
        wr(A_RSTEN, 32'hFFFF_FFFF); rdreg(A_RSTEN, rd); chk("R10 rsten readback", rd, 32'h100);
        chk("R10 req asserted", {31'd0, rst_req}, 1);
        wr(A_RMASK, 32'hFFFF_FFFF); rdreg(A_RMASK, rd); chk("R10 mask readback", rd, 32'h400);
        chk("R10 masked", {31'd0, rst_req}, 0);
        wr(A_RMASK, 0); chk("R10 unmasked", {31'd0, rst_req}, 1);
        wr(A_CTRL, 0); chk("R10 disabled", {31'd0, rst_req}, 0);
        wr(A_CTRL, EN); wr(A_STAT, 0); chk("R10 flag cleared", {31'd0, rst_req}, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule